// File: doc/BRIEF.md
# Shift, Rotate and Flag Unit

This block is the single-operand bit-manipulation stage of a small microcontroller datapath. It accepts one operation per accepted transfer: an operation code, an operand byte, a bit index and a status-flag index. It returns the result byte in the same cycle and keeps the 8-bit status register that the operations read and update. The supported operations are:

- logical shifts left and right;
- rotates left and right through carry;
- arithmetic shift right;
- nibble exchange;
- copying a register bit into or out of the transfer flag;
- forcing any one status flag to 1 or to 0.

Operations arrive on a valid/ready stream and leave on a valid/ready stream. The block has no internal buffering. The result is combinational from the input, so `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A downstream stall therefore stalls the producer in the same cycle. The status register changes only on a clock edge at which a transfer is accepted, meaning `in_valid` and `out_ready` are both high. An offered but stalled operation leaves every flag untouched. Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.

Top module: `sru_top`

## Requirements
- R1: Opcode 0 (shift left) gives `{in_data[6:0],0}`. Opcode 1 (shift right) gives `{0,in_data[7:1]}`.
- R2: Opcode 2 (rotate left) gives `{in_data[6:0],C}`. Opcode 3 (rotate right) gives `{C,in_data[7:1]}`. C is the status bit 0 value before the edge.
- R3: Opcode 4 (arithmetic shift right) gives `{in_data[7],in_data[7:1]}`.
- R4: After an accepted opcode 0 or 2, C (bit 0) equals the old `in_data[7]`. After an accepted opcode 1, 3 or 4, C equals the old `in_data[0]`.
- R5: After an accepted opcode 0 to 4:
  - N (bit 2) equals result bit 7;
  - Z (bit 1) is 1 exactly when the result is zero;
  - V (bit 3) equals N XOR C;
  - S, H, T and I (bits 4 to 7) are unchanged.
- R6: Opcode 5 (nibble swap) gives `{in_data[3:0],in_data[7:4]}` and leaves the status register unchanged.
- R7: Opcode 6 (bit store) copies `in_data[in_bit]` into T (bit 6), changes no other flag, and passes `in_data` through as the result.
- R8: Opcode 7 (bit load) gives `in_data` with bit `in_bit` replaced by the current T, and changes no flag.
- R9: Opcode 8 sets and opcode 9 clears status bit `in_flag`. Both leave every other status bit unchanged and pass `in_data` through.
- R10: Opcodes 10 to 15 pass `in_data` through and change no flag.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The status register is written only at an edge where `in_valid` and `out_ready` are both high.
- R12: While `rst_n` is low the status register is cleared to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_op | input | 4 | Operation code |
| in_data | input | 8 | Operand byte |
| in_bit | input | 3 | Bit index for bit store / bit load |
| in_flag | input | 3 | Status bit index for flag set / clear |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | 8 | Result byte |
| status | output | 8 | Status register |

## Verification
A flag write from one operation and a flag read by the next can meet at the same edge. This happens when a bit store is followed, with no idle cycle, by a bit load, or when a rotate follows a shift that changed carry. The bench keeps `in_valid` high across both operations. It checks that the second result uses the flag value committed at the edge between them. It also holds an operation under back-pressure for a cycle, which places a stall on top of an offered flag change, and checks that the status stays put until the transfer is accepted.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int STAT_W = 8;
  localparam int FIDX_W = 3;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_RTL  = 4'd2,
    OP_RTR  = 4'd3,
    OP_SAR  = 4'd4,
    OP_NSWP = 4'd5,
    OP_TST  = 4'd6,
    OP_TLD  = 4'd7,
    OP_FON  = 4'd8,
    OP_FOFF = 4'd9
  } sru_op_e;
endpackage

// File: rtl/sru_shift.sv
module sru_shift #(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          hit,
  output logic          swap_hit
);
  import sru_pkg::*;
  localparam int HALF = DW / 2;

  always_comb begin
    res      = a;
    cout     = 1'b0;
    hit      = 1'b1;
    swap_hit = 1'b0;
    case (op)
      OP_SHL: begin
        res  = {a[DW-2:0], 1'b0};
        cout = a[DW-1];
      end
      OP_SHR: begin
        res  = {1'b0, a[DW-1:1]};
        cout = a[0];
      end
      OP_RTL: begin
        res  = {a[DW-2:0], cin};
        cout = a[DW-1];
      end
      OP_RTR: begin
        res  = {cin, a[DW-1:1]};
        cout = a[0];
      end
      OP_SAR: begin
        res  = {a[DW-1], a[DW-1:1]};
        cout = a[0];
      end
      OP_NSWP: begin
        res      = {a[HALF-1:0], a[DW-1:HALF]};
        hit      = 1'b0;
        swap_hit = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/sru_bitop.sv
module sru_bitop #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic [3:0]                  op,
  input  logic [DW-1:0]               a,
  input  logic [BW-1:0]               bsel,
  input  logic [sru_pkg::FIDX_W-1:0]  fsel,
  input  logic                        t_in,
  output logic [DW-1:0]               res,
  output logic [sru_pkg::STAT_W-1:0]  f_en,
  output logic [sru_pkg::STAT_W-1:0]  f_val
);
  import sru_pkg::*;

  logic [DW-1:0]     bit_mask;
  logic [STAT_W-1:0] flag_mask;

  assign bit_mask  = {{(DW-1){1'b0}}, 1'b1} << bsel;
  assign flag_mask = {{(STAT_W-1){1'b0}}, 1'b1} << fsel;

  always_comb begin
    res   = a;
    f_en  = '0;
    f_val = '0;
    case (op)
      OP_TST: begin
        f_en[FLG_T]  = 1'b1;
        f_val[FLG_T] = a[bsel];
      end
      OP_TLD: begin
        res = t_in ? (a | bit_mask) : (a & ~bit_mask);
      end
      OP_FON: begin
        f_en  = flag_mask;
        f_val = flag_mask;
      end
      OP_FOFF: begin
        f_en  = flag_mask;
        f_val = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sru_status.sv
module sru_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [SW-1:0] upd_en,
  input  logic [SW-1:0] upd_val,
  output logic [SW-1:0] q
);
  for (genvar i = 0; i < SW; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (commit && upd_en[i])
        q[i] <= upd_val[i];
    end
  end
endmodule

// File: rtl/sru_top.sv
module sru_top #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [3:0]                 in_op,
  input  logic [DW-1:0]              in_data,
  input  logic [BW-1:0]              in_bit,
  input  logic [sru_pkg::FIDX_W-1:0] in_flag,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [DW-1:0]              out_data,
  output logic [sru_pkg::STAT_W-1:0] status
);
  import sru_pkg::*;

  logic [DW-1:0]     sh_res, bo_res;
  logic              sh_cout, sh_hit, sh_swap;
  logic [STAT_W-1:0] bo_en, bo_val;
  logic [STAT_W-1:0] upd_en, upd_val;
  logic              sh_n, sh_z;
  logic              take;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign take      = in_valid && out_ready;

  sru_shift #(.DW(DW)) u_shift (
    .op(in_op), .a(in_data), .cin(status[FLG_C]),
    .res(sh_res), .cout(sh_cout), .hit(sh_hit), .swap_hit(sh_swap)
  );

  sru_bitop #(.DW(DW)) u_bitop (
    .op(in_op), .a(in_data), .bsel(in_bit), .fsel(in_flag),
    .t_in(status[FLG_T]), .res(bo_res), .f_en(bo_en), .f_val(bo_val)
  );

  assign sh_n = sh_res[DW-1];
  assign sh_z = (sh_res == '0);

  always_comb begin
    if (sh_hit) begin
      upd_en         = '0;
      upd_val        = '0;
      upd_en[FLG_C]  = 1'b1;
      upd_en[FLG_Z]  = 1'b1;
      upd_en[FLG_N]  = 1'b1;
      upd_en[FLG_V]  = 1'b1;
      upd_val[FLG_C] = sh_cout;
      upd_val[FLG_Z] = sh_z;
      upd_val[FLG_N] = sh_n;
      upd_val[FLG_V] = sh_n ^ sh_cout;
    end else begin
      upd_en  = bo_en;
      upd_val = bo_val;
    end
  end

  assign out_data = (sh_hit || sh_swap) ? sh_res : bo_res;

  sru_status #(.SW(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .commit(take),
    .upd_en(upd_en), .upd_val(upd_val), .q(status)
  );
endmodule

// File: rtl/sru_chk.sv
module sru_chk #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [3:0]                 in_op,
  input logic [DW-1:0]              in_data,
  input logic [BW-1:0]              in_bit,
  input logic [sru_pkg::FIDX_W-1:0] in_flag,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW-1:0]              out_data,
  input logic [sru_pkg::STAT_W-1:0] status
);
  logic acc;
  assign acc = in_valid && out_ready;

  p_no_take_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(status));

  p_left_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd0 || in_op == 4'd2) |=> status[0] == $past(in_data[DW-1]));

  p_right_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd1 || in_op == 4'd3 || in_op == 4'd4) |=> status[0] == $past(in_data[0]));

  p_overflow_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op <= 4'd4 |=> status[3] == (status[2] ^ status[0]));

  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op <= 4'd4 |=> status[7:4] == $past(status[7:4]));

  p_swap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd5 |=> $stable(status));

  p_tstore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd6 |=> status[6] == $past(in_data[in_bit]));

  p_fset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd8 |=> status[$past(in_flag)] == 1'b1);

  p_fclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd9 |=> status[$past(in_flag)] == 1'b0);

  p_shl_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_op == 4'd0 |-> out_data == {in_data[DW-2:0], 1'b0});

  p_stream_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> status == '0);
endmodule

bind sru_top sru_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_sru_top.sv
module sim_sru_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [3:0] in_op;
  logic [7:0] in_data, out_data, status;
  logic [2:0] in_bit, in_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mst;

  always #5 clk = ~clk;

  sru_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_bit(in_bit), .in_flag(in_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .status(status)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] op, input logic [7:0] d,
                                input logic [2:0] b, input logic [2:0] f,
                                input logic [7:0] s,
                                output logic [7:0] r, output logic [7:0] ns);
    logic c;
    ns = s;
    r  = d;
    c  = 1'b0;
    case (op)
      4'd0: begin r = d << 1; c = d[7]; end
      4'd1: begin r = d >> 1; c = d[0]; end
      4'd2: begin r = {d[6:0], s[0]}; c = d[7]; end
      4'd3: begin r = {s[0], d[7:1]}; c = d[0]; end
      4'd4: begin r = {d[7], d[7:1]}; c = d[0]; end
      4'd5: r = {d[3:0], d[7:4]};
      4'd6: ns[6] = d[b];
      4'd7: r[b] = s[6];
      4'd8: ns[f] = 1'b1;
      4'd9: ns[f] = 1'b0;
      default: ;
    endcase
    if (op <= 4'd4) begin
      ns[0] = c;
      ns[1] = (r == 8'h00);
      ns[2] = r[7];
      ns[3] = r[7] ^ c;
    end
  endfunction

  // Issue one operation at the next falling edge; it is accepted at the next rising edge.
  task automatic issue(input string req, input logic [3:0] op, input logic [7:0] d,
                       input logic [2:0] b, input logic [2:0] f);
    logic [7:0] er, es;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    in_op = op; in_data = d; in_bit = b; in_flag = f;
    model(op, d, b, f, mst, er, es);
    #1;
    check({req, " result"}, out_data, er);
    @(posedge clk);
    #1;
    mst = es;
    check({req, " status"}, status, es);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = 4'd8; in_data = 8'h00; in_bit = 3'd0; in_flag = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset status", status, 8'h00);
    mst = 8'h00;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_shifts();
    issue("R1 shl", 4'd0, 8'hA5, 3'd0, 3'd0);
    issue("R1 shr", 4'd1, 8'hA5, 3'd0, 3'd0);
    issue("R1 R5 shl to zero", 4'd0, 8'h80, 3'd0, 3'd0);
    issue("R3 sar neg", 4'd4, 8'h81, 3'd0, 3'd0);
    issue("R3 sar pos", 4'd4, 8'h42, 3'd0, 3'd0);
    idle();
  endtask

  task automatic t_rotates();
    issue("R9 set C", 4'd8, 8'h00, 3'd0, 3'd0);
    issue("R2 R4 rtl with C", 4'd2, 8'h40, 3'd0, 3'd0);
    issue("R2 R4 rtr", 4'd3, 8'h01, 3'd0, 3'd0);
    issue("R2 rtl carry chain", 4'd2, 8'h80, 3'd0, 3'd0);
    issue("R2 rtr carry chain", 4'd3, 8'h00, 3'd0, 3'd0);
    idle();
  endtask

  task automatic t_upper_kept();
    issue("R9 set I", 4'd8, 8'h00, 3'd0, 3'd7);
    issue("R9 set H", 4'd8, 8'h00, 3'd0, 3'd5);
    issue("R9 set S", 4'd8, 8'h00, 3'd0, 3'd4);
    issue("R5 shift keeps S H I", 4'd1, 8'h03, 3'd0, 3'd0);
    issue("R9 clear H", 4'd9, 8'hFF, 3'd0, 3'd5);
    issue("R9 clear C", 4'd9, 8'h00, 3'd0, 3'd0);
    idle();
  endtask

  task automatic t_swap_unused();
    issue("R6 swap", 4'd5, 8'h3C, 3'd0, 3'd0);
    issue("R6 swap2", 4'd5, 8'hF1, 3'd0, 3'd0);
    for (int op = 10; op < 16; op++)
      issue("R10 unused op", op[3:0], 8'h5A, 3'd3, 3'd2);
    idle();
  endtask

  // Bit store followed immediately by bit load: the load sees the T just committed.
  task automatic t_tflag_back_to_back();
    issue("R7 store T=1", 4'd6, 8'h08, 3'd3, 3'd0);
    issue("R8 load T into bit0", 4'd7, 8'h00, 3'd0, 3'd0);
    issue("R7 store T=0", 4'd6, 8'hF7, 3'd3, 3'd0);
    issue("R8 load T into bit7", 4'd7, 8'hFF, 3'd7, 3'd0);
    idle();
  endtask

  task automatic t_backpressure();
    logic [7:0] er, es;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    in_op = 4'd8; in_data = 8'h00; in_flag = 3'd1; in_bit = 3'd0;
    #1;
    check("R11 ready follows", {7'd0, in_ready}, 8'h00);
    check("R11 valid follows", {7'd0, out_valid}, 8'h01);
    @(posedge clk); #1;
    check("R11 stalled no write", status, mst);
    @(negedge clk);
    out_ready = 1'b1;
    model(4'd8, 8'h00, 3'd0, 3'd1, mst, er, es);
    #1;
    check("R11 ready high", {7'd0, in_ready}, 8'h01);
    @(posedge clk); #1;
    mst = es;
    check("R11 accepted write", status, es);
    @(negedge clk);
    in_valid = 1'b0; in_op = 4'd9; in_flag = 3'd1;
    @(posedge clk); #1;
    check("R11 idle no write", status, mst);
    check("R11 valid low", {7'd0, out_valid}, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_shifts();
        t_rotates();
        t_upper_kept();
        t_swap_unused();
        t_tflag_back_to_back();
        t_backpressure();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule